// File: doc/BRIEF.md
# DMA Ready Signal Generator

This block produces the active-low transmit-ready and receive-ready request lines that a four-channel UART presents to an external DMA controller when it runs block transfers. For every channel it watches the transmit and receive FIFO fill counts, the transmit-full and receive-empty flags, and a per-channel pair of 8-bit programmable trigger levels. It drives one transmit-ready and one receive-ready line per channel, plus a shared pair that follows whichever channel a 2-bit select input names.

The request lines have hysteresis. Transmit ready is raised (driven low) once the transmit FIFO holds fewer characters than its trigger level, and is then kept until the FIFO is completely full. Receive ready is raised once the receive FIFO holds more characters than its trigger level, and is then kept until the FIFO is completely empty. Between the two thresholds each line keeps its previous state. This lets the DMA controller move a whole block per request instead of toggling around one level. The state for each direction of each channel is a registered flag. The FIFOs, serial engines and DMA controller lie outside the block, and their counts and flags arrive as plain inputs. No data moves through the block, so it has no valid/ready interface.

Top module: `dma_ready_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every `tx_rdy_n` bit is 0 (asserted) and every `rx_rdy_n` bit is 1 (deasserted). The shared pair follows the selected channel.
- R2: If a channel's `tx_full` is 0 and its transmit count is strictly below its transmit trigger at a rising clock edge, its `tx_rdy_n` bit is 0 after that edge.
- R3: If a channel's `tx_full` is 1 at a rising clock edge, its `tx_rdy_n` bit is 1 after that edge.
- R4: If `tx_full` is 0 and the transmit count is at or above the trigger, `tx_rdy_n` keeps its previous value across the edge.
- R5: If a channel's `rx_empty` is 0 and its receive count is strictly above its receive trigger at a rising clock edge, its `rx_rdy_n` bit is 0 after that edge.
- R6: If a channel's `rx_empty` is 1 at a rising clock edge, its `rx_rdy_n` bit is 1 after that edge.
- R7: If `rx_empty` is 0 and the receive count is at or below the trigger, `rx_rdy_n` keeps its previous value across the edge.
- R8: `tx_rdy_sel_n` equals `tx_rdy_n[ch_sel]` and `rx_rdy_sel_n` equals `rx_rdy_n[ch_sel]` in the same cycle, with no register between them.
- R9: Each channel's outputs depend only on that channel's inputs. Channel k uses bits [9k+8:9k] of each count bus and bits [8k+7:8k] of each trigger bus.
- R10: Counts are unsigned and range from 0 to 256. `tx_full` is set only when the count is 256, and `rx_empty` is set exactly when the count is 0. With a transmit trigger of 0 the transmit line never re-asserts. With a receive trigger of 255 the receive line asserts only at a count of 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_cnt | input | 36 | Transmit FIFO fill counts, 9 bits per channel |
| rx_cnt | input | 36 | Receive FIFO fill counts, 9 bits per channel |
| tx_full | input | 4 | Transmit FIFO full flag per channel |
| rx_empty | input | 4 | Receive FIFO empty flag per channel |
| tx_trig | input | 32 | Transmit trigger levels, 8 bits per channel |
| rx_trig | input | 32 | Receive trigger levels, 8 bits per channel |
| ch_sel | input | 2 | Channel shown on the shared pair |
| tx_rdy_n | output | 4 | Transmit ready per channel, active low |
| rx_rdy_n | output | 4 | Receive ready per channel, active low |
| tx_rdy_sel_n | output | 1 | Transmit ready of the selected channel, active low |
| rx_rdy_sel_n | output | 1 | Receive ready of the selected channel, active low |

## Verification
The assertions take the FIFO inputs to be self-consistent. No count exceeds 256. `tx_full` appears only at a count of 256, and `rx_empty` is high exactly when the receive count is zero. Under these conditions the full and empty overrides can never meet an opposing threshold condition. The stimulus derives both flags from the count it drives on every cycle. It walks each channel's counts from 0 to 256 and back for several trigger levels, including 0 and 255. The idle channels are held at values that sit inside the hold band.

// File: rtl/dmardy_pkg.sv
package dmardy_pkg;
  localparam int unsigned DEF_NUM_CH = 4;
  localparam int unsigned DEF_CNT_W  = 9;
  localparam int unsigned DEF_TRIG_W = 8;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;
endpackage

// File: rtl/dmardy_hyst.sv
module dmardy_hyst
  import dmardy_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned TRIG_W = DEF_TRIG_W,
  parameter dir_e        DIR    = DIR_TX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [TRIG_W-1:0] trig,
  input  logic              stop_flag,
  output logic              active
);
  localparam logic RST_VAL = (DIR == DIR_TX) ? 1'b1 : 1'b0;

  logic [CNT_W-1:0] trig_ext;
  logic             start_hit;
  logic             nxt;

  assign trig_ext = CNT_W'(trig);

  generate
    if (DIR == DIR_TX) begin : g_tx
      assign start_hit = (cnt < trig_ext);
    end else begin : g_rx
      assign start_hit = (cnt > trig_ext);
    end
  endgenerate

  always_comb begin
    nxt = active;
    if (stop_flag)      nxt = 1'b0;
    else if (start_hit) nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= RST_VAL;
    else        active <= nxt;
  end
endmodule

// File: rtl/dmardy_chan.sv
module dmardy_chan
  import dmardy_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned TRIG_W = DEF_TRIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [TRIG_W-1:0] rx_trig,
  output logic              tx_rdy_n,
  output logic              rx_rdy_n
);
  logic tx_act;
  logic rx_act;

  dmardy_hyst #(.CNT_W(CNT_W), .TRIG_W(TRIG_W), .DIR(DIR_TX)) tx_hyst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (tx_cnt),
    .trig      (tx_trig),
    .stop_flag (tx_full),
    .active    (tx_act)
  );

  dmardy_hyst #(.CNT_W(CNT_W), .TRIG_W(TRIG_W), .DIR(DIR_RX)) rx_hyst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (rx_cnt),
    .trig      (rx_trig),
    .stop_flag (rx_empty),
    .active    (rx_act)
  );

  assign tx_rdy_n = ~tx_act;
  assign rx_rdy_n = ~rx_act;
endmodule

// File: rtl/dmardy_sel.sv
module dmardy_sel #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] tx_in,
  input  logic [NUM_CH-1:0] rx_in,
  input  logic [SEL_W-1:0]  sel,
  output logic              tx_out,
  output logic              rx_out
);
  always_comb begin
    tx_out = 1'b1;
    rx_out = 1'b1;
    for (int k = 0; k < NUM_CH; k++) begin
      if (sel == SEL_W'(k)) begin
        tx_out = tx_in[k];
        rx_out = rx_in[k];
      end
    end
  end
endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen
  import dmardy_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned TRIG_W = DEF_TRIG_W,
  parameter int unsigned SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*CNT_W-1:0]  tx_cnt,
  input  logic [NUM_CH*CNT_W-1:0]  rx_cnt,
  input  logic [NUM_CH-1:0]        tx_full,
  input  logic [NUM_CH-1:0]        rx_empty,
  input  logic [NUM_CH*TRIG_W-1:0] tx_trig,
  input  logic [NUM_CH*TRIG_W-1:0] rx_trig,
  input  logic [SEL_W-1:0]         ch_sel,
  output logic [NUM_CH-1:0]        tx_rdy_n,
  output logic [NUM_CH-1:0]        rx_rdy_n,
  output logic                     tx_rdy_sel_n,
  output logic                     rx_rdy_sel_n
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmardy_chan #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) chan_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_cnt   (tx_cnt[c*CNT_W +: CNT_W]),
        .rx_cnt   (rx_cnt[c*CNT_W +: CNT_W]),
        .tx_full  (tx_full[c]),
        .rx_empty (rx_empty[c]),
        .tx_trig  (tx_trig[c*TRIG_W +: TRIG_W]),
        .rx_trig  (rx_trig[c*TRIG_W +: TRIG_W]),
        .tx_rdy_n (tx_rdy_n[c]),
        .rx_rdy_n (rx_rdy_n[c])
      );
    end
  endgenerate

  dmardy_sel #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) sel_i (
    .tx_in  (tx_rdy_n),
    .rx_in  (rx_rdy_n),
    .sel    (ch_sel),
    .tx_out (tx_rdy_sel_n),
    .rx_out (rx_rdy_sel_n)
  );
endmodule

// File: rtl/dma_ready_gen_chk.sv
module dma_ready_gen_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned TRIG_W = 8,
  parameter int unsigned SEL_W  = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CH*CNT_W-1:0]  tx_cnt,
  input logic [NUM_CH*CNT_W-1:0]  rx_cnt,
  input logic [NUM_CH-1:0]        tx_full,
  input logic [NUM_CH-1:0]        rx_empty,
  input logic [NUM_CH*TRIG_W-1:0] tx_trig,
  input logic [NUM_CH*TRIG_W-1:0] rx_trig,
  input logic [SEL_W-1:0]         ch_sel,
  input logic [NUM_CH-1:0]        tx_rdy_n,
  input logic [NUM_CH-1:0]        rx_rdy_n,
  input logic                     tx_rdy_sel_n,
  input logic                     rx_rdy_sel_n
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(1 << TRIG_W);

  a_r8_shared_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rdy_sel_n == tx_rdy_n[ch_sel]);
  a_r8_shared_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy_sel_n == rx_rdy_n[ch_sel]);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      logic [CNT_W-1:0] tc, rc, tt, rt;
      assign tc = tx_cnt[i*CNT_W +: CNT_W];
      assign rc = rx_cnt[i*CNT_W +: CNT_W];
      assign tt = CNT_W'(tx_trig[i*TRIG_W +: TRIG_W]);
      assign rt = CNT_W'(rx_trig[i*TRIG_W +: TRIG_W]);

      a_r2_tx_assert: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_full[i] && tc < tt) |=> !tx_rdy_n[i]);
      a_r3_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full[i] |=> tx_rdy_n[i]);
      a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_full[i] && tc >= tt) |=> $stable(tx_rdy_n[i]));
      a_r5_rx_assert: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_empty[i] && rc > rt) |=> !rx_rdy_n[i]);
      a_r6_rx_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty[i] |=> rx_rdy_n[i]);
      a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_empty[i] && rc <= rt) |=> $stable(rx_rdy_n[i]));
      a_r10_tx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tc <= CAP) && (!tx_full[i] || tc == CAP));
      a_r10_rx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rc <= CAP) && (rx_empty[i] == (rc == '0)));
    end
  endgenerate
endmodule

bind dma_ready_gen dma_ready_gen_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .TRIG_W(TRIG_W), .SEL_W(SEL_W)
) chk_i (.*);

// File: tb/dma_ready_gen_tb.sv
module dma_ready_gen_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 9;
  localparam int TW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH*CW-1:0] tx_cnt, rx_cnt;
  logic [NCH-1:0]    tx_full, rx_empty;
  logic [NCH*TW-1:0] tx_trig, rx_trig;
  logic [1:0]        ch_sel;
  logic [NCH-1:0]    tx_rdy_n, rx_rdy_n;
  logic              tx_rdy_sel_n, rx_rdy_sel_n;

  int tcnt [NCH];
  int rcnt [NCH];
  int ttrg [NCH];
  int rtrg [NCH];
  bit exp_tx [NCH];
  bit exp_rx [NCH];
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      tx_cnt[c*CW +: CW]  = CW'(tcnt[c]);
      rx_cnt[c*CW +: CW]  = CW'(rcnt[c]);
      tx_full[c]          = (tcnt[c] == 256);
      rx_empty[c]         = (rcnt[c] == 0);
      tx_trig[c*TW +: TW] = TW'(ttrg[c]);
      rx_trig[c*TW +: TW] = TW'(rtrg[c]);
    end
  end

  dma_ready_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_full(tx_full), .rx_empty(rx_empty), .tx_trig(tx_trig),
    .rx_trig(rx_trig), .ch_sel(ch_sel), .tx_rdy_n(tx_rdy_n),
    .rx_rdy_n(rx_rdy_n), .tx_rdy_sel_n(tx_rdy_sel_n),
    .rx_rdy_sel_n(rx_rdy_sel_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Idle channels sit in the hold band of both directions (R9).
  task automatic idle(input int c);
    tcnt[c] = 128; ttrg[c] = 128;
    rcnt[c] = 64;  rtrg[c] = 128;
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++) begin
      check({req, " tx"}, tx_rdy_n[c], ~exp_tx[c]);
      check({req, " rx"}, rx_rdy_n[c], ~exp_rx[c]);
    end
    for (int s = 0; s < NCH; s++) begin
      ch_sel = 2'(s);
      #1;
      check("R8 shared tx", tx_rdy_sel_n, ~exp_tx[s]);
      check("R8 shared rx", rx_rdy_sel_n, ~exp_rx[s]);
    end
  endtask

  // Inputs are applied at a falling edge; model and check follow.
  task automatic step(input string req);
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (tcnt[c] == 256)          exp_tx[c] = 1'b0; // R3
      else if (tcnt[c] < ttrg[c])  exp_tx[c] = 1'b1; // R2, else hold R4
      if (rcnt[c] == 0)            exp_rx[c] = 1'b0; // R6
      else if (rcnt[c] > rtrg[c])  exp_rx[c] = 1'b1; // R5, else hold R7
    end
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    int trigs [5] = '{0, 1, 128, 254, 255};
    ch_sel = 2'd0;
    for (int c = 0; c < NCH; c++) begin
      idle(c);
      exp_tx[c] = 1'b1;
      exp_rx[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");
    for (int c = 0; c < NCH; c++) begin
      for (int t = 0; t < 5; t++) begin
        ttrg[c] = trigs[t];
        rtrg[c] = trigs[NCH - 1 - (t % NCH)];
        for (int v = 0; v <= 256; v++) begin
          tcnt[c] = v; rcnt[c] = v;
          step("R2 R3 R4 R5 R6 R7 R9 R10 up");
        end
        for (int v = 256; v >= 0; v--) begin
          tcnt[c] = v; rcnt[c] = v;
          step("R2 R3 R4 R5 R6 R7 R9 R10 down");
        end
      end
      idle(c);
      step("R9 idle");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule